// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 16-bit virtual address into an 18-bit physical address. It uses segment registers held inside the block. The top three virtual address bits pick one of eight segments. Each segment has a base register and a descriptor. The base gives where the segment starts in physical memory, in 64-byte units. The descriptor gives:
- the segment length in 64-byte blocks;
- whether the segment grows up or down;
- a two-bit access code;
- a dirty flag that the hardware sets.

There are three privilege modes: kernel, supervisor and user. Each mode has an instruction set and a data set of eight segment register pairs, so the block holds 48 pairs in all. A split bit for each mode decides whether data accesses in that mode use the data set or share the instruction set.

A requester presents an access with these fields:
- the virtual address;
- the mode;
- an instruction-class flag, raised for opcode, immediate-operand and absolute-address fetches;
- a write flag.

The request FSM has two states. In `ST_IDLE` it is ready. An accepted request moves it to `ST_CHECK` (transition IDLE->CHECK). The only transition out of `ST_CHECK` is back to `ST_IDLE` (CHECK->IDLE). On that transition the block registers a one-cycle response: the physical address and a fault strobe.

Software programs the registers through a simple read/write port. Software also clears the captured fault record through this port. A faulting access is aborted: its physical address reads as zero and it does not set the dirty flag.

Top module: `segxlat_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. The control word, the split word and every base and descriptor register read as 0.
- R2: While control bit 0 (translation enable) is 0, every response carries `rsp_paddr` equal to the zero-extended virtual address and `rsp_fault`=0. This holds whatever the descriptors, the mode or the access type.
- R3: A request seen with `req_valid`=1 and `req_ready`=1 at a rising edge gives the following:
  - `req_ready` is 0 for the next cycle;
  - `rsp_valid` is 1 for exactly one cycle, after the second following edge;
  - `rsp_fault` is only ever 1 while `rsp_valid` is 1.
- R4: With translation on, a legal access to segment `vaddr[15:13]` returns `{base,6'b0} + vaddr[12:0]`, taken modulo 2^18.
- R5: The descriptor length field is bits [7:0], counted in 64-byte blocks. Values above 128 act as 128. For an upward segment (bit 8 = 0), the access faults unless `vaddr[12:0]` < length×64. A length of 0 faults on every access.
- R6: For a downward segment (bit 8 = 1), the access faults unless `vaddr[12:0]` ≥ 8192 − length×64. The valid region is therefore the top of the 8 KB window.
- R7: The access code is descriptor bits [10:9]:
  - 00 and 10 allow nothing;
  - 01 allows reads only;
  - 11 allows reads and writes.
  Any access the code does not allow faults.
- R8: Split word bit m controls mode m (0 kernel, 1 supervisor, 2 user). When bit m is 1, instruction-class accesses of mode m use its instruction set (space 0) and all other accesses use its data set (space 1). When bit m is 0, every access of mode m uses the instruction set.
- R9: A request with mode code 3 faults when translation is on.
- R10: A faulting response has `rsp_paddr`=0. If no fault is held, the block records the fault in the control word and stores the virtual address in the fault-address register. The control word fields are:
  - bit 15: a fault is held;
  - bit 14: length fault;
  - bit 13: access fault;
  - bit 12: mode fault;
  - bits 6:5: mode;
  - bit 4: space;
  - bits 3:1: segment.
- R11: While bit 15 is 1, later faults change neither the control word nor the fault address. A software write to the control word loads bit 0 from the written data and clears bits 15..1.
- R12: Descriptor bit 11 (dirty) is set by a non-faulting write with translation on. Reads and faulting writes leave it unchanged. A software write to the descriptor clears it, whatever the written value of bit 11.
- R13: Software addresses are 7 bits, decoded as follows:
  - for bits [6:5] = 0 to 2: bits [6:5] give the mode, bit 4 the space (1 = data), bit 3 selects the base (1) or the descriptor (0), and bits [2:0] the segment;
  - 0x60 is the control word;
  - 0x61 is the read-only fault address;
  - 0x62 is the split word.
  Base registers keep 12 bits and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_vaddr | input | 16 | Virtual address |
| req_mode | input | 2 | 0 kernel, 1 supervisor, 2 user, 3 illegal |
| req_ifetch | input | 1 | Access is instruction class |
| req_write | input | 1 | Access is a write |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 18 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Access aborted |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | 7 | Software register address |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Software read data (combinational) |

## Verification
Length checking is swept across every 64-byte block of a segment, for several length values. The values include 0, 1, the full 128 and an over-range 200, and each is tried in both growth directions. This separates off-by-one boundary errors from mistakes in the direction or the clamping. The split selection is tried with every value of the three-bit split word, in every mode, for both fetch classes. Each pairing is given distinct instruction and data bases, so a wrong bit index or a wrong space shows up as a wrong base. Access codes are crossed with reads and writes. Pass-through mode is tried across all modes with all-zero descriptors, which shows that no check leaks into it. Fault records are examined for the first capture, a blocked second capture, and captures after clearing for each of the three fault kinds.

// File: rtl/segxlat_pkg.sv
`timescale 1ns/1ps
package segxlat_pkg;
    localparam int VA_W   = 16;
    localparam int SEG_W  = 3;
    localparam int BLK_SH = 6;
    localparam int BASE_W = 12;
    localparam int NMODE  = 3;
    localparam int MODE_W = 2;
    localparam int OFF_W  = VA_W - SEG_W;
    localparam int BIDX_W = OFF_W - BLK_SH;
    localparam int LEN_W  = BIDX_W + 1;
    localparam int PA_W   = BASE_W + BLK_SH;
    localparam int NSEG   = 1 << SEG_W;
    localparam int IDX_W  = MODE_W + 1 + SEG_W;
    localparam int NSET   = NMODE * 2 * NSEG;
    localparam int SW_AW  = IDX_W + 1;
    localparam int SW_DW  = 16;
    localparam int NMCODE = 1 << MODE_W;

    localparam logic [1:0] ACC_RO = 2'b01;
    localparam logic [1:0] ACC_RW = 2'b11;

    localparam logic [SW_AW-1:0] A_CTL   = 7'h60;
    localparam logic [SW_AW-1:0] A_FLTVA = 7'h61;
    localparam logic [SW_AW-1:0] A_SPLIT = 7'h62;

    typedef enum logic {ST_IDLE, ST_CHECK} xl_state_e;

    typedef struct packed {
        logic             dirty;
        logic [1:0]       acc;
        logic             down;
        logic [LEN_W-1:0] len;
    } seg_desc_t;

    typedef struct packed {
        logic len_f;
        logic acc_f;
        logic mode_f;
    } flt_kind_t;
endpackage

// File: rtl/segxlat_regbank.sv
`timescale 1ns/1ps
module segxlat_regbank
    import segxlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [SW_AW-1:0]  sw_addr,
    input  logic [SW_DW-1:0]  sw_wdata,
    output logic [SW_DW-1:0]  sw_rdata,
    input  logic [IDX_W-1:0]  lk_idx,
    output seg_desc_t         lk_desc,
    output logic [BASE_W-1:0] lk_base,
    input  logic              dirty_set,
    input  logic [IDX_W-1:0]  dirty_idx,
    input  logic              flt_log,
    input  flt_kind_t         flt_kind,
    input  logic [MODE_W-1:0] flt_mode,
    input  logic              flt_space,
    input  logic [VA_W-1:0]   flt_va,
    output logic              xlat_en,
    output logic [NMODE-1:0]  split_en,
    output logic              flt_flag,
    output logic [VA_W-1:0]   flt_va_q
);
    seg_desc_t         desc_q [NSET];
    logic [BASE_W-1:0] base_q [NSET];

    logic              sw_seg;
    logic [IDX_W-1:0]  sw_idx;
    logic              sw_isbase;
    logic              ctl_wr;

    logic              en_q;
    logic [NMODE-1:0]  split_q;
    logic              fflag_q;
    flt_kind_t         fkind_q;
    logic [MODE_W-1:0] fmode_q;
    logic              fspace_q;
    logic [SEG_W-1:0]  fseg_q;
    logic [VA_W-1:0]   fva_q;
    logic [SW_DW-1:0]  ctl_word;
    logic              unused_wbits;

    assign sw_seg    = sw_addr[SW_AW-1 -: MODE_W] != {MODE_W{1'b1}};
    assign sw_idx    = {sw_addr[SW_AW-1:SEG_W+1], sw_addr[SEG_W-1:0]};
    assign sw_isbase = sw_addr[SEG_W];
    assign ctl_wr    = sw_we && (sw_addr == A_CTL);
    assign unused_wbits = ^sw_wdata[SW_DW-1:$bits(seg_desc_t)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSET; i++) begin
                desc_q[i] <= '0;
                base_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSET; i++) begin
                if (sw_we && sw_seg && sw_idx == IDX_W'(i) && sw_isbase)
                    base_q[i] <= sw_wdata[BASE_W-1:0];
                if (sw_we && sw_seg && sw_idx == IDX_W'(i) && !sw_isbase)
                    desc_q[i] <= seg_desc_t'({1'b0, sw_wdata[$bits(seg_desc_t)-2:0]});
                else if (dirty_set && dirty_idx == IDX_W'(i))
                    desc_q[i].dirty <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            split_q  <= '0;
            fflag_q  <= 1'b0;
            fkind_q  <= '0;
            fmode_q  <= '0;
            fspace_q <= 1'b0;
            fseg_q   <= '0;
            fva_q    <= '0;
        end else begin
            if (sw_we && sw_addr == A_SPLIT)
                split_q <= sw_wdata[NMODE-1:0];
            if (ctl_wr) begin
                en_q     <= sw_wdata[0];
                fflag_q  <= 1'b0;
                fkind_q  <= '0;
                fmode_q  <= '0;
                fspace_q <= 1'b0;
                fseg_q   <= '0;
            end else if (flt_log && !fflag_q) begin
                fflag_q  <= 1'b1;
                fkind_q  <= flt_kind;
                fmode_q  <= flt_mode;
                fspace_q <= flt_space;
                fseg_q   <= flt_va[VA_W-1 -: SEG_W];
                fva_q    <= flt_va;
            end
        end
    end

    assign ctl_word = {fflag_q, fkind_q, 5'b0, fmode_q, fspace_q, fseg_q, en_q};

    always_comb begin
        sw_rdata = '0;
        if (sw_seg) begin
            if (sw_isbase)
                sw_rdata[BASE_W-1:0] = base_q[sw_idx];
            else
                sw_rdata[$bits(seg_desc_t)-1:0] = desc_q[sw_idx];
        end else begin
            case (sw_addr)
                A_CTL:   sw_rdata = ctl_word;
                A_FLTVA: sw_rdata = fva_q;
                A_SPLIT: sw_rdata[NMODE-1:0] = split_q;
                default: sw_rdata = '0;
            endcase
        end
    end

    assign lk_desc  = desc_q[lk_idx];
    assign lk_base  = base_q[lk_idx];
    assign xlat_en  = en_q;
    assign split_en = split_q;
    assign flt_flag = fflag_q;
    assign flt_va_q = fva_q;
endmodule

// File: rtl/segxlat_check.sv
`timescale 1ns/1ps
module segxlat_check
    import segxlat_pkg::*;
(
    input  logic              en,
    input  logic              mode_ok,
    input  logic              write,
    input  logic [VA_W-1:0]   vaddr,
    input  seg_desc_t         desc,
    input  logic [BASE_W-1:0] base,
    output logic [PA_W-1:0]   paddr,
    output logic              fault,
    output flt_kind_t         kind
);
    localparam int FULL = 1 << BIDX_W;

    logic [BIDX_W-1:0] blk;
    logic [LEN_W-1:0]  len_eff;
    logic [LEN_W-1:0]  lo_lim;
    logic              len_ok;
    logic              acc_ok;
    logic              unused_bits;

    assign blk         = vaddr[OFF_W-1:BLK_SH];
    assign unused_bits = ^{vaddr[VA_W-1:OFF_W], desc.dirty};

    always_comb begin
        len_eff = (desc.len > LEN_W'(FULL)) ? LEN_W'(FULL) : desc.len;
        lo_lim  = LEN_W'(FULL) - len_eff;
        len_ok  = desc.down ? ({1'b0, blk} >= lo_lim) : ({1'b0, blk} < len_eff);
        acc_ok  = write ? (desc.acc == ACC_RW)
                        : (desc.acc == ACC_RO || desc.acc == ACC_RW);
        kind.mode_f = en && !mode_ok;
        kind.acc_f  = en && mode_ok && !acc_ok;
        kind.len_f  = en && mode_ok && !len_ok;
        fault = kind.mode_f || kind.acc_f || kind.len_f;
        if (!en)
            paddr = PA_W'(vaddr);
        else if (fault)
            paddr = '0;
        else
            paddr = {base, {BLK_SH{1'b0}}} + PA_W'(vaddr[OFF_W-1:0]);
    end
endmodule

// File: rtl/segxlat_fsm.sv
`timescale 1ns/1ps
module segxlat_fsm
    import segxlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_ifetch,
    input  logic              req_write,
    input  logic              xlat_en,
    input  logic [NMODE-1:0]  split_en,
    input  logic [PA_W-1:0]   chk_paddr,
    input  logic              chk_fault,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [IDX_W-1:0]  lk_idx,
    output logic              lk_mode_ok,
    output logic              lk_write,
    output logic [VA_W-1:0]   lk_vaddr,
    output logic [MODE_W-1:0] lk_mode,
    output logic              lk_space,
    output logic              dirty_set,
    output logic              flt_log
);
    xl_state_e         state, nxt;
    logic [VA_W-1:0]   lat_vaddr;
    logic [MODE_W-1:0] lat_mode;
    logic              lat_ifetch;
    logic              lat_write;
    logic [NMCODE-1:0] split_ext;
    logic              in_check;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = req_valid ? ST_CHECK : ST_IDLE;
            ST_CHECK: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_vaddr  <= '0;
            lat_mode   <= '0;
            lat_ifetch <= 1'b0;
            lat_write  <= 1'b0;
        end else if (state == ST_IDLE && req_valid) begin
            lat_vaddr  <= req_vaddr;
            lat_mode   <= req_mode;
            lat_ifetch <= req_ifetch;
            lat_write  <= req_write;
        end
    end

    assign in_check   = (state == ST_CHECK);
    assign split_ext  = NMCODE'(split_en);
    assign lk_mode_ok = lat_mode < MODE_W'(NMODE);
    assign lk_space   = lk_mode_ok && split_ext[lat_mode] && !lat_ifetch;
    assign lk_idx     = {lk_mode_ok ? lat_mode : {MODE_W{1'b0}}, lk_space,
                         lat_vaddr[VA_W-1 -: SEG_W]};
    assign lk_write   = lat_write;
    assign lk_vaddr   = lat_vaddr;
    assign lk_mode    = lat_mode;
    assign req_ready  = (state == ST_IDLE);
    assign dirty_set  = in_check && xlat_en && lat_write && !chk_fault;
    assign flt_log    = in_check && chk_fault;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= in_check;
            rsp_fault <= in_check && chk_fault;
            if (in_check)
                rsp_paddr <= chk_paddr;
        end
    end
endmodule

// File: rtl/segxlat_top.sv
`timescale 1ns/1ps
module segxlat_top
    import segxlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_ifetch,
    input  logic              req_write,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    input  logic              sw_we,
    input  logic [SW_AW-1:0]  sw_addr,
    input  logic [SW_DW-1:0]  sw_wdata,
    output logic [SW_DW-1:0]  sw_rdata
);
    logic              xlat_en;
    logic [NMODE-1:0]  split_en;
    logic              flt_flag;
    logic [VA_W-1:0]   flt_va_q;
    logic [IDX_W-1:0]  lk_idx;
    seg_desc_t         lk_desc;
    logic [BASE_W-1:0] lk_base;
    logic              lk_mode_ok;
    logic              lk_write;
    logic [VA_W-1:0]   lk_vaddr;
    logic [MODE_W-1:0] lk_mode;
    logic              lk_space;
    logic [PA_W-1:0]   chk_paddr;
    logic              chk_fault;
    flt_kind_t         chk_kind;
    logic              dirty_set;
    logic              flt_log;

    segxlat_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_mode(req_mode),
        .req_ifetch(req_ifetch), .req_write(req_write),
        .xlat_en(xlat_en), .split_en(split_en),
        .chk_paddr(chk_paddr), .chk_fault(chk_fault),
        .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .lk_idx(lk_idx), .lk_mode_ok(lk_mode_ok), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .lk_mode(lk_mode), .lk_space(lk_space),
        .dirty_set(dirty_set), .flt_log(flt_log)
    );

    segxlat_check u_check (
        .en(xlat_en), .mode_ok(lk_mode_ok), .write(lk_write),
        .vaddr(lk_vaddr), .desc(lk_desc), .base(lk_base),
        .paddr(chk_paddr), .fault(chk_fault), .kind(chk_kind)
    );

    segxlat_regbank u_regs (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .lk_idx(lk_idx), .lk_desc(lk_desc), .lk_base(lk_base),
        .dirty_set(dirty_set), .dirty_idx(lk_idx),
        .flt_log(flt_log), .flt_kind(chk_kind), .flt_mode(lk_mode),
        .flt_space(lk_space), .flt_va(lk_vaddr),
        .xlat_en(xlat_en), .split_en(split_en),
        .flt_flag(flt_flag), .flt_va_q(flt_va_q)
    );
endmodule

// File: rtl/segxlat_sva.sv
`timescale 1ns/1ps
module segxlat_sva
    import segxlat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             xlat_en,
    input logic             flt_flag,
    input logic [VA_W-1:0]  flt_va_q,
    input logic             sw_we,
    input logic [SW_AW-1:0] sw_addr
);
    p_accept_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready ##1 rsp_valid);

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_fault_in_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    p_fault_zero_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> rsp_paddr == '0);

    p_off_no_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(xlat_en)) |-> !rsp_fault);

    p_fault_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flt_flag) && !$past(sw_we && sw_addr == A_CTL))
            |-> (flt_flag && $stable(flt_va_q)));
endmodule

bind segxlat_top segxlat_sva u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .xlat_en(xlat_en), .flt_flag(flt_flag), .flt_va_q(flt_va_q),
    .sw_we(sw_we), .sw_addr(sw_addr)
);

// File: tb/tb_segxlat_top.sv
`timescale 1ns/1ps
module tb_segxlat_top;
    import segxlat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ifetch, req_write, req_ready;
    logic [15:0] req_vaddr;
    logic [1:0]  req_mode;
    logic        rsp_valid, rsp_fault;
    logic [17:0] rsp_paddr;
    logic        sw_we;
    logic [6:0]  sw_addr;
    logic [15:0] sw_wdata, sw_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    segxlat_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_mode(req_mode), .req_ifetch(req_ifetch), .req_write(req_write),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ra(input int m, input int sp, input int isb, input int seg);
        return 7'((m << 5) | (sp << 4) | (isb << 3) | seg);
    endfunction

    function automatic logic [15:0] dw(input int len, input int down, input int acc);
        return 16'((acc << 9) | (down << 8) | len);
    endfunction

    task automatic sw_wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        sw_addr = a;
        #1 d = sw_rdata;
    endtask

    task automatic xl(input logic [15:0] v, input logic [1:0] m, input logic f,
                      input logic w, output logic [17:0] pa, output logic fl);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v; req_mode = m; req_ifetch = f; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R3 response strobe", rsp_valid, 1);
        pa = rsp_paddr;
        fl = rsp_fault;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [17:0] pa;
        logic        fl;
        int          lens[7] = '{0, 1, 37, 64, 127, 128, 200};

        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_mode = '0;
        req_ifetch = 1'b0; req_write = 1'b0; sw_we = 1'b0; sw_addr = '0; sw_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        sw_rd(A_CTL, rd);   chk("R1 ctl", rd, 0);
        sw_rd(A_SPLIT, rd); chk("R1 split", rd, 0);
        sw_rd(ra(2, 1, 0, 6), rd); chk("R1 desc", rd, 0);
        sw_rd(ra(1, 0, 1, 3), rd); chk("R1 base", rd, 0);

        // R3 handshake timing
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'h1234; req_mode = 2'd0; req_ifetch = 1'b0; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 busy", req_ready, 0);
        chk("R3 no early rsp", rsp_valid, 0);
        @(negedge clk);
        chk("R3 rsp", rsp_valid, 1);
        chk("R3 ready again", req_ready, 1);
        @(negedge clk);
        chk("R3 one cycle", rsp_valid, 0);

        // R2 pass-through while disabled, all descriptors no-access
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] v;
                v = 16'((k * 4099 + m * 777 + (k == 15 ? 65535 : 0)) & 16'hFFFF);
                xl(v, 2'(m), k[1], k[0], pa, fl);
                chk("R2 paddr", pa, {2'b0, v});
                chk("R2 fault", fl, 0);
            end
        end

        // R13 register map
        for (int s = 0; s < 8; s++) begin
            sw_wr(ra(0, 0, 1, s), 16'(12'h0A0 + s * 12'h111));
            sw_wr(ra(0, 0, 0, s), dw(128, 0, 3) | 16'h0800);
        end
        sw_wr(ra(0, 0, 1, 7), 16'hFFFF);
        sw_rd(ra(0, 0, 1, 2), rd); chk("R13 base readback", rd, 16'h0A0 + 16'h222);
        sw_rd(ra(0, 0, 1, 7), rd); chk("R13 base width", rd, 16'h0FFF);
        sw_rd(ra(0, 0, 0, 4), rd); chk("R13 desc readback", rd, 16'h0680);
        sw_rd(ra(0, 1, 1, 2), rd); chk("R13 other set untouched", rd, 0);
        sw_wr(A_FLTVA, 16'hBEEF);
        sw_rd(A_FLTVA, rd); chk("R13 fault addr read-only", rd, 0);

        // R4 translation
        sw_wr(A_CTL, 16'h0001);
        for (int s = 0; s < 8; s++) begin
            int bs;
            bs = (s == 7) ? 12'hFFF : 12'h0A0 + s * 12'h111;
            for (int j = 0; j < 3; j++) begin
                int off;
                off = (j == 0) ? 0 : (j == 1) ? 16'h1FFF : ((s * 16'h123 + 5) & 16'h1FFF);
                xl(16'((s << 13) | off), 2'd0, 1'b0, 1'b0, pa, fl);
                chk("R4 fault", fl, 0);
                chk("R4 paddr", pa, 18'((bs * 64 + off) & 18'h3FFFF));
            end
        end

        // R5 upward length sweep, R6 downward length sweep
        sw_wr(ra(0, 0, 1, 1), 16'h040);
        sw_wr(ra(0, 0, 1, 6), 16'h300);
        for (int dn = 0; dn < 2; dn++) begin
            for (int li = 0; li < 7; li++) begin
                int seg, le, bs;
                seg = dn ? 6 : 1;
                bs  = dn ? 16'h300 : 16'h040;
                le  = (lens[li] > 128) ? 128 : lens[li];
                sw_wr(ra(0, 0, 0, seg), dw(lens[li], dn, 1));
                for (int b = 0; b < 128; b++) begin
                    int  off;
                    logic ok;
                    off = b * 64 + ((b * 7) % 64);
                    ok  = dn ? (off >= 8192 - le * 64) : (off < le * 64);
                    xl(16'((seg << 13) | off), 2'd0, 1'b1, 1'b0, pa, fl);
                    if (dn) begin
                        chk("R6 down fault", fl, !ok);
                        chk("R6 down paddr", pa, ok ? 18'(bs * 64 + off) : 18'd0);
                    end else begin
                        chk("R5 up fault", fl, !ok);
                        chk("R5 up paddr", pa, ok ? 18'(bs * 64 + off) : 18'd0);
                    end
                end
            end
        end

        // R7 access codes
        for (int a = 0; a < 4; a++) begin
            sw_wr(ra(0, 0, 0, 2), dw(128, 0, a));
            for (int w = 0; w < 2; w++) begin
                logic exf;
                exf = w ? (a != 3) : !(a == 1 || a == 3);
                xl(16'h4321, 2'd0, 1'b0, 1'(w), pa, fl);
                chk("R7 access fault", fl, exf);
            end
        end

        // R8 split selection, all split words, all modes, both classes
        for (int m = 0; m < 3; m++) begin
            sw_wr(ra(m, 0, 1, 3), 16'(12'h100 + m));
            sw_wr(ra(m, 1, 1, 3), 16'(12'h200 + m));
            sw_wr(ra(m, 0, 0, 3), dw(128, 0, 3));
            sw_wr(ra(m, 1, 0, 3), dw(128, 0, 3));
        end
        for (int sv = 0; sv < 8; sv++) begin
            sw_wr(A_SPLIT, 16'(sv));
            for (int m = 0; m < 3; m++) begin
                for (int f = 0; f < 2; f++) begin
                    int bs;
                    bs = (((sv >> m) & 1) == 1 && f == 0) ? 12'h200 + m : 12'h100 + m;
                    xl(16'h6055, 2'(m), 1'(f), 1'b0, pa, fl);
                    chk("R8 split fault", fl, 0);
                    chk("R8 split base", pa, 18'(bs * 64 + 16'h0055));
                end
            end
        end

        // R9 illegal mode
        for (int k = 0; k < 4; k++) begin
            xl(16'(k * 16'h3001), 2'd3, k[0], k[1], pa, fl);
            chk("R9 mode fault", fl, 1);
            chk("R10 fault paddr zero", pa, 0);
        end

        // R10 / R11 fault capture and freeze
        sw_wr(A_SPLIT, 16'h0000);
        sw_wr(A_CTL, 16'h0001);
        sw_rd(A_CTL, rd); chk("R11 clear", rd, 16'h0001);
        sw_wr(ra(0, 0, 0, 2), dw(128, 0, 1));
        xl(16'h4ABC, 2'd0, 1'b0, 1'b1, pa, fl);
        chk("R10 ro write fault", fl, 1);
        chk("R10 paddr zero", pa, 0);
        sw_rd(A_CTL, rd);   chk("R10 ctl access", rd, 16'hA005);
        sw_rd(A_FLTVA, rd); chk("R10 fault addr", rd, 16'h4ABC);
        xl(16'hE123, 2'd3, 1'b0, 1'b0, pa, fl);
        chk("R11 second fault strobes", fl, 1);
        sw_rd(A_CTL, rd);   chk("R11 ctl frozen", rd, 16'hA005);
        sw_rd(A_FLTVA, rd); chk("R11 addr frozen", rd, 16'h4ABC);
        sw_wr(A_CTL, 16'h8001);
        sw_rd(A_CTL, rd);   chk("R11 cleared by write", rd, 16'h0001);
        sw_wr(ra(0, 0, 0, 5), dw(2, 0, 1));
        xl(16'hA100, 2'd0, 1'b0, 1'b0, pa, fl);
        chk("R10 length fault", fl, 1);
        sw_rd(A_CTL, rd);   chk("R10 ctl length", rd, 16'hC00B);
        sw_wr(A_CTL, 16'h0001);
        xl(16'hE123, 2'd3, 1'b0, 1'b0, pa, fl);
        sw_rd(A_CTL, rd);   chk("R10 ctl mode", rd, 16'h906F);
        sw_rd(A_FLTVA, rd); chk("R10 fault addr mode", rd, 16'hE123);
        sw_wr(A_CTL, 16'h0001);
        sw_wr(A_SPLIT, 16'h0004);
        xl(16'h0040, 2'd2, 1'b0, 1'b0, pa, fl);
        sw_rd(A_CTL, rd);   chk("R10 ctl user data space", rd, 16'hE051);
        sw_wr(A_SPLIT, 16'h0000);

        // R12 dirty flag
        sw_wr(ra(0, 0, 0, 4), dw(128, 0, 3));
        xl(16'h8010, 2'd0, 1'b0, 1'b0, pa, fl);
        sw_rd(ra(0, 0, 0, 4), rd); chk("R12 read keeps clean", rd, 16'h0680);
        xl(16'h8010, 2'd0, 1'b0, 1'b1, pa, fl);
        chk("R12 write ok", fl, 0);
        sw_rd(ra(0, 0, 0, 4), rd); chk("R12 write sets dirty", rd, 16'h0E80);
        sw_wr(ra(0, 0, 0, 4), dw(128, 0, 3) | 16'h0800);
        sw_rd(ra(0, 0, 0, 4), rd); chk("R12 sw write clears", rd, 16'h0680);
        xl(16'hA010, 2'd0, 1'b0, 1'b1, pa, fl);
        chk("R12 faulting write", fl, 1);
        sw_rd(ra(0, 0, 0, 5), rd); chk("R12 fault leaves clean", rd, 16'h0202);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule